// File: doc/BRIEF.md
# Servo Command Serial Port

This block receives 8-bit commands over a slow three-wire port (serial clock, serial data, latch strobe) and turns them into the digital switch enables of an optical-disc servo front end. A fast system clock samples all port pins through synchronizer chains. Commands shift in least significant bit first. A rising latch strobe applies the byte that has been assembled. The upper nibble of the byte picks one of four register groups: focus switches, tracking gain, tracking/sled mode and level select. The same nibble also picks the comparator signal that a single status pin presents to the controller.

Two analog-side signals act on the decoded state without a serial write. The anti-shock input can invert both tracking-gain switches when anti-shock is armed. The active-low direct-control pin reverses the direction of a running tracking jump, so that an acceleration pulse becomes a deceleration pulse. When that pin is released, the tracking and sled servos both switch on. This lets the controller finish a one-track jump without a second serial transfer.

Top module: `servo_cmd_port`

## Requirements
- R1: The shift register shifts right on each synchronized rising edge of `ser_clk`, and the `ser_data` value enters at bit 7. After eight clocks, the first bit sent (D0) is at bit 0. When more than eight clocks arrive, only the last eight bits are kept. No output changes until a latch is applied.
- R2: On a synchronized rising edge of `ser_latch`, a byte with upper nibble 0000 loads its bits D3..D0 into `focus_sw[3:0]`.
- R3: Upper nibble 0001 loads the gain group: D0 tracking gain 1, D1 tracking gain 2, D2 brake, D3 anti-shock arm. When the arm bit is 1 and `shock_in` is high, `tg1_en` and `tg2_en` both show the inverse of their stored bits.
- R4: Upper nibble 0010 loads the tracking mode from D3:D2 onto the outputs: 00 gives all off, 01 gives `trk_servo`, 10 gives `trk_fwd` and 11 gives `trk_rev`.
- R5: In the same byte, D1:D0 set the sled mode: 00 gives all off, 01 gives `sled_servo`, 10 gives `sled_fwd` and 11 gives `sled_rev`.
- R6: Upper nibble 0011 loads D3..D0 into `level_sel[3:0]`.
- R7: The last latched group selects the status output, with `sens_oe`=1: group 0 shows `fzc_in`, 1 shows `shock_in`, 2 shows `tzc_in` and 3 shows `limit_in`. Any upper nibble of 4 or above sets `sens_oe`=0 and `sens_out`=0, and writes no register.
- R8: Each group register keeps its value until a byte of that same group is latched.
- R9: While `dir_n` is low, a tracking jump runs in the opposite direction: a forward jump drives `trk_rev` and a reverse jump drives `trk_fwd`. The servo-on and off modes are not affected.
- R10: A synchronized rising edge of `dir_n` sets both the tracking mode and the sled mode to servo on (01).
- R11: While `rst_n` is low, every register clears. After reset, all switch outputs are 0 and `sens_oe`=1 with FZC selected.
- R12: Each latch clears the shift register to zero. A byte latched after k<8 clocks therefore holds the k bits sent in its top k positions and zeros below them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial port clock |
| ser_data | input | 1 | Serial port data |
| ser_latch | input | 1 | Latch strobe; rising edge applies the byte |
| dir_n | input | 1 | Direct-control pin, active low, idle high |
| fzc_in | input | 1 | Focus zero-cross comparator |
| tzc_in | input | 1 | Tracking zero-cross comparator |
| shock_in | input | 1 | Anti-shock detector |
| limit_in | input | 1 | Inner limit switch |
| focus_sw | output | 4 | Focus switches, bit n = switch n+1 |
| brake_en | output | 1 | Tracking brake enable |
| tg1_en | output | 1 | Tracking gain switch 1 |
| tg2_en | output | 1 | Tracking gain switch 2 |
| trk_servo | output | 1 | Tracking servo closed |
| trk_fwd | output | 1 | Forward jump pulse |
| trk_rev | output | 1 | Reverse jump pulse |
| sled_servo | output | 1 | Sled servo closed |
| sled_fwd | output | 1 | Sled forward kick |
| sled_rev | output | 1 | Sled reverse kick |
| level_sel | output | 4 | Search and kick level select |
| sens_out | output | 1 | Selected status signal |
| sens_oe | output | 1 | Status output enable |

## Verification
The bench builds the block with `SYNC_STAGES` = 3. Each pin edge therefore takes one more cycle to act than it does with the default, and the bench's settle times must cover that longer path. With the port clock running at one fifth of the real rate, all 256 byte values can be latched in turn. After each latch, every output is compared with a model that tracks each group's register and the status selection. The model exercises all group decodes, the high-impedance codes and register retention. Directed sequences add partial and overlong frames, anti-shock inversion and the direct-control jump reversal and release.

// File: rtl/servo_cmd_port.sv
module servo_cmd_port #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk,
  input  logic       ser_data,
  input  logic       ser_latch,
  input  logic       dir_n,
  input  logic       fzc_in,
  input  logic       tzc_in,
  input  logic       shock_in,
  input  logic       limit_in,
  output logic [3:0] focus_sw,
  output logic       brake_en,
  output logic       tg1_en,
  output logic       tg2_en,
  output logic       trk_servo,
  output logic       trk_fwd,
  output logic       trk_rev,
  output logic       sled_servo,
  output logic       sled_fwd,
  output logic       sled_rev,
  output logic [3:0] level_sel,
  output logic       sens_out,
  output logic       sens_oe
);
  localparam logic [3:0] PIN_IDLE = 4'b1000;

  logic [3:0] sync_q [SYNC_STAGES];
  logic [3:0] prev_q;
  logic [3:0] pins_s;
  logic       clk_rise, latch_rise, dir_rise, dir_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= PIN_IDLE;
      prev_q <= PIN_IDLE;
    end else begin
      sync_q[0] <= {dir_n, ser_latch, ser_data, ser_clk};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= pins_s;
    end
  end

  assign pins_s     = sync_q[SYNC_STAGES-1];
  assign clk_rise   = pins_s[0] & ~prev_q[0];
  assign latch_rise = pins_s[2] & ~prev_q[2];
  assign dir_rise   = pins_s[3] & ~prev_q[3];
  assign dir_low    = ~pins_s[3];

  logic [7:0] shreg;
  logic [3:0] focus_r, gain_r, mode_r, level_r;
  logic [1:0] grp_r;
  logic       hiz_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      focus_r <= '0;
      gain_r  <= '0;
      mode_r  <= '0;
      level_r <= '0;
      grp_r   <= '0;
      hiz_r   <= 1'b0;
    end else begin
      if (latch_rise) begin
        shreg <= '0;
        if (shreg[7:6] == 2'b00) begin
          grp_r <= shreg[5:4];
          hiz_r <= 1'b0;
          case (shreg[5:4])
            2'd0:    focus_r <= shreg[3:0];
            2'd1:    gain_r  <= shreg[3:0];
            2'd2:    mode_r  <= shreg[3:0];
            default: level_r <= shreg[3:0];
          endcase
        end else begin
          hiz_r <= 1'b1;
        end
      end else if (clk_rise) begin
        shreg <= {pins_s[1], shreg[7:1]};
      end
      if (dir_rise) mode_r <= 4'b0101;
    end
  end

  logic trk_jump, trk_pol;
  assign trk_jump = mode_r[3];
  assign trk_pol  = mode_r[2] ^ dir_low;

  assign focus_sw   = focus_r;
  assign level_sel  = level_r;
  assign brake_en   = gain_r[2];
  assign tg1_en     = gain_r[0] ^ (gain_r[3] & shock_in);
  assign tg2_en     = gain_r[1] ^ (gain_r[3] & shock_in);
  assign trk_servo  = mode_r[3:2] == 2'b01;
  assign trk_fwd    = trk_jump & ~trk_pol;
  assign trk_rev    = trk_jump &  trk_pol;
  assign sled_servo = mode_r[1:0] == 2'b01;
  assign sled_fwd   = mode_r[1:0] == 2'b10;
  assign sled_rev   = mode_r[1:0] == 2'b11;

  logic sens_mux;
  always_comb begin
    case (grp_r)
      2'd0:    sens_mux = fzc_in;
      2'd1:    sens_mux = shock_in;
      2'd2:    sens_mux = tzc_in;
      default: sens_mux = limit_in;
    endcase
  end

  assign sens_oe  = ~hiz_r;
  assign sens_out = sens_mux & ~hiz_r;
endmodule

module servo_cmd_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       latch_rise,
  input logic       dir_rise,
  input logic [3:0] focus_r,
  input logic [3:0] level_r,
  input logic       trk_servo,
  input logic       trk_fwd,
  input logic       trk_rev,
  input logic       sled_servo,
  input logic       sled_fwd,
  input logic       sled_rev,
  input logic       sens_out,
  input logic       sens_oe
);
  a_r2_focus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_rise |=> $stable(focus_r));
  a_r8_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_rise |=> $stable(level_r));
  a_r10_release_on: assert property (@(posedge clk) disable iff (!rst_n)
    dir_rise |=> (trk_servo && sled_servo));
  a_r4_trk_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trk_servo, trk_fwd, trk_rev}));
  a_r5_sled_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sled_servo, sled_fwd, sled_rev}));
  a_r7_hiz_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sens_oe |-> !sens_out);
endmodule

bind servo_cmd_port servo_cmd_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .latch_rise(latch_rise), .dir_rise(dir_rise),
  .focus_r(focus_r), .level_r(level_r),
  .trk_servo(trk_servo), .trk_fwd(trk_fwd), .trk_rev(trk_rev),
  .sled_servo(sled_servo), .sled_fwd(sled_fwd), .sled_rev(sled_rev),
  .sens_out(sens_out), .sens_oe(sens_oe)
);

// File: tb/test_servo_cmd_port.sv
module test_servo_cmd_port;
  localparam int HALF = 20;

  logic clk = 0, rst_n = 0;
  logic ser_clk = 0, ser_data = 0, ser_latch = 0, dir_n = 1;
  logic fzc_in = 0, tzc_in = 0, shock_in = 0, limit_in = 0;
  logic [3:0] focus_sw, level_sel;
  logic brake_en, tg1_en, tg2_en, trk_servo, trk_fwd, trk_rev;
  logic sled_servo, sled_fwd, sled_rev, sens_out, sens_oe;

  servo_cmd_port #(.SYNC_STAGES(3)) i_servo_cmd_port (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [3:0] m_focus = 0, m_gain = 0, m_mode = 0, m_level = 0;
  logic [1:0] m_grp = 0;
  logic m_hiz = 0;

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Model: apply a latched byte (R2..R8)
  task automatic model_apply(input logic [7:0] b);
    if (b[7:4] < 4) begin
      m_grp = b[5:4];
      m_hiz = 0;
      case (b[5:4])
        2'd0: m_focus = b[3:0];
        2'd1: m_gain  = b[3:0];
        2'd2: m_mode  = b[3:0];
        default: m_level = b[3:0];
      endcase
    end else m_hiz = 1;
  endtask

  // Serial frame of nbits, bit i sent i-th; model per R1/R12
  task automatic send(input logic [15:0] v, input int nbits);
    logic [7:0] eff = 0;
    for (int i = 0; i < nbits; i++) begin
      ser_data = v[i];
      eff = {v[i], eff[7:1]};
      wait_cyc(HALF);
      ser_clk = 1;
      wait_cyc(HALF);
      ser_clk = 0;
    end
    wait_cyc(HALF);
    ser_latch = 1;
    wait_cyc(HALF);
    ser_latch = 0;
    wait_cyc(HALF);
    model_apply(eff);
  endtask

  task automatic check_all();
    int js = (m_gain[3] & shock_in) ? 1 : 0;
    int t = m_mode[3:2];
    int pol = m_mode[2] ^ (dir_n ? 0 : 1);
    int sv;
    case (m_grp)
      2'd0: sv = fzc_in;
      2'd1: sv = shock_in;
      2'd2: sv = tzc_in;
      default: sv = limit_in;
    endcase
    chk("R2 focus_sw", focus_sw, m_focus);
    chk("R3 brake", brake_en, m_gain[2]);
    chk("R3 tg1", tg1_en, m_gain[0] ^ js);
    chk("R3 tg2", tg2_en, m_gain[1] ^ js);
    chk("R4 trk_servo", trk_servo, t == 1);
    chk("R4_R9 trk_fwd", trk_fwd, m_mode[3] && pol == 0);
    chk("R4_R9 trk_rev", trk_rev, m_mode[3] && pol == 1);
    chk("R5 sled_servo", sled_servo, m_mode[1:0] == 1);
    chk("R5 sled_fwd", sled_fwd, m_mode[1:0] == 2);
    chk("R5 sled_rev", sled_rev, m_mode[1:0] == 3);
    chk("R6 level_sel", level_sel, m_level);
    chk("R7 sens_oe", sens_oe, !m_hiz);
    chk("R7 sens_out", sens_out, m_hiz ? 0 : sv);
  endtask

  initial begin
    wait_cyc(5);
    // R11: reset state, FZC on status pin
    fzc_in = 1;
    wait_cyc(1);
    chk("R11 reset sens", sens_out, 1);
    rst_n = 1;
    wait_cyc(5);
    check_all();
    chk("R11 focus after reset", focus_sw, 0);

    // Exhaustive byte sweep (R2..R8)
    for (int v = 0; v < 256; v++) begin
      logic [3:0] pat = 4'((v * 5 + 3) & 15);
      {limit_in, tzc_in, shock_in, fzc_in} = pat;
      send(16'(v), 8);
      check_all();
    end

    // R1: outputs unchanged by clocks without latch
    send(16'h05, 8);
    for (int i = 0; i < 8; i++) begin
      ser_data = 1; wait_cyc(HALF); ser_clk = 1; wait_cyc(HALF); ser_clk = 0;
    end
    wait_cyc(HALF);
    chk("R1 no change before latch", focus_sw, 4'h5);
    ser_latch = 1; wait_cyc(HALF); ser_latch = 0; wait_cyc(HALF);
    model_apply(8'hFF);
    check_all();

    // R1: overlong frame keeps last 8 bits (last 8 form 0x37)
    send(16'h37 << 2 | 16'h3, 10);
    chk("R1 overlong frame level", level_sel, 4'h7);

    // R12: partial frame after mode set
    send(16'h25, 8);
    send(16'h2, 4);
    chk("R12 partial frame mode off", {trk_servo, sled_servo}, 0);
    check_all();

    // R8: other groups untouched
    send(16'h0A, 8);
    send(16'h16, 8);
    send(16'h3C, 8);
    chk("R8 focus kept", focus_sw, 4'hA);
    check_all();

    // R3: anti-shock inversion
    send(16'h19, 8);
    shock_in = 1; wait_cyc(2);
    chk("R3 shock tg1 inverted", tg1_en, 0);
    chk("R3 shock tg2 inverted", tg2_en, 1);
    shock_in = 0; wait_cyc(2);
    chk("R3 shock released tg1", tg1_en, 1);

    // R9/R10: direct control
    send(16'h28, 8);
    chk("R9 fwd jump", trk_fwd, 1);
    dir_n = 0; wait_cyc(10);
    chk("R9 dir low reverses fwd", {trk_fwd, trk_rev}, 2'b01);
    dir_n = 1; wait_cyc(10);
    m_mode = 4'b0101;
    chk("R10 release trk servo", trk_servo, 1);
    chk("R10 release sled servo", sled_servo, 1);
    check_all();
    send(16'h2C, 8);
    dir_n = 0; wait_cyc(10);
    chk("R9 dir low reverses rev", {trk_fwd, trk_rev}, 2'b10);
    check_all();
    dir_n = 1; wait_cyc(10);
    m_mode = 4'b0101;
    send(16'h25, 8);
    dir_n = 0; wait_cyc(10);
    chk("R9 servo unaffected", {trk_servo, trk_fwd, trk_rev}, 3'b100);
    dir_n = 1; wait_cyc(10);
    check_all();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule